// File: doc/BRIEF.md
# Display Latch Window and Ready Controller

This block sits between the serial front end of a multiplexed segment-display driver and its output stage. On every rising edge of the frame strobe it decides, from two configuration flags and a "data was written in this frame" indication, whether the display memory is to be copied into the output holding register. When a copy is started it emits a one-cycle copy pulse and pulls the ready line low for a fixed number of oscillator half-periods. The full default window is 1009 half-periods, which is 504.5 full oscillator periods.

The block also owns the power-up handshake, the abort path and the display-enable flag. After reset the ready line stays low until the strobe moves in either direction. A strobe edge that arrives while a copy window is open cancels the window, asks the serial front end to start over in command mode, and switches the display off. The display-enable flag is loaded from a pending status command on a strobe rising edge. It is gated with an external active-low blanking pin to produce the effective display-active output.

Top module: `disp_latch_ctrl`

## Requirements
- R1: After reset, `busy` (1 = ready) is 0, `disp_on` is 0 and `latch_pulse` is 0. These values hold for as long as `strobe` does not change, whatever the flag inputs are. `strobe` is held at 1 while `rst` is high.
- R2: In the power-up state, the first `strobe` edge of either polarity raises `busy` and gives a one-cycle `ser_reinit` pulse in the cycle after that edge. It does not give a `latch_pulse`.
- R3: While ready, a `strobe` rising edge starts a copy exactly when `latch_every` = 1, or when `latch_mode` = 1 and `data_seen` = 1. In every other flag combination it does not start a copy. A falling edge never starts a copy.
- R4: A copy gives a `latch_pulse` that lasts one cycle and drives `busy` low from that same cycle. `busy` stays low until `WIN_TICKS` cycles with `osc_tick` = 1 have been counted, and rises in the cycle after the last of them.
- R5: Only cycles with `osc_tick` = 1 advance the copy window, so with gaps in the tick the window lengthens in clock cycles but keeps the same tick count.
- R6: A `strobe` edge while a copy window is open ends the window in the next cycle. In that cycle `busy` = 1, `ser_reinit` pulses, `disp_on` = 0, and no `latch_pulse` is issued for that edge.
- R7: While ready, a `strobe` rising edge with `stat_pend` = 1 loads `stat_on` into `disp_on`. With `stat_pend` = 0 the rising edge leaves `disp_on` unchanged.
- R8: `disp_active` = `disp_on` AND `disp_off_n`. Driving `disp_off_n` low changes neither `disp_on` nor the copy behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator half-period |
| strobe | input | 1 | Frame strobe, already synchronised, low during a frame |
| latch_mode | input | 1 | Copy after data frames only |
| latch_every | input | 1 | Copy on every strobe rising edge |
| data_seen | input | 1 | A data transfer took place in the current frame |
| stat_pend | input | 1 | A status command with a display-enable value is pending |
| stat_on | input | 1 | Display-enable value of the pending status command |
| disp_off_n | input | 1 | External blanking pin, low blanks the display |
| busy | output | 1 | Ready line: 1 = ready, 0 = power-up or copy in progress |
| latch_pulse | output | 1 | One-cycle command to copy display memory to the output register |
| ser_reinit | output | 1 | One-cycle request to reset the serial front end to command mode |
| disp_on | output | 1 | Display-enable flag |
| disp_active | output | 1 | Effective display enable after blanking |

## Verification
The copy decision is swept over all eight combinations of the two latch flags and the data indication. Each combination gets a falling edge followed by a rising edge, which separates a correct OR-of-terms decode from one that drops a term and from one that reacts to the wrong strobe polarity. The window length is measured in counted ticks under a continuous tick and under one-in-three gapped ticks, which exposes off-by-one terminal counts and counters that advance without a tick. The abort, power-up and display-enable sequences are driven with the blanking pin in both states, to show that blanking and flag updates stay independent.

// File: rtl/disp_latch_pkg.sv
package disp_latch_pkg;

    typedef enum logic [1:0] {
        ST_POWERUP = 2'd0,
        ST_READY   = 2'd1,
        ST_COPY    = 2'd2
    } ctl_state_t;

    typedef struct packed {
        logic mode;
        logic every;
        logic data;
    } copy_cfg_t;

    function automatic logic copy_wanted(input copy_cfg_t cfg);
        return cfg.every | (cfg.mode & cfg.data);
    endfunction

endpackage

// File: rtl/disp_strobe_edge.sv
module disp_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic rise,
    output logic fall,
    output logic any_edge
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= strobe;
    end

    assign rise     = strobe & ~prev_q;
    assign fall     = ~strobe & prev_q;
    assign any_edge = rise | fall;
endmodule

// File: rtl/disp_copy_window.sv
module disp_copy_window #(
    parameter int WIN_TICKS = 1009
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    input  logic tick,
    output logic done
);
    localparam int CNT_W = $clog2(WIN_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_TICKS - 1);

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;

    assign done = run_q & tick & (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (run_q && tick) begin
            if (cnt_q == LAST) begin
                run_q <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R4
    window_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (cnt_q <= LAST));

    // R5
    idle_count_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && !tick && !start && !abort) |=> $stable(cnt_q));
endmodule

// File: rtl/disp_latch_ctrl.sv
module disp_latch_ctrl #(
    parameter int WIN_TICKS = 1009
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_tick,
    input  logic strobe,
    input  logic latch_mode,
    input  logic latch_every,
    input  logic data_seen,
    input  logic stat_pend,
    input  logic stat_on,
    input  logic disp_off_n,
    output logic busy,
    output logic latch_pulse,
    output logic ser_reinit,
    output logic disp_on,
    output logic disp_active
);
    import disp_latch_pkg::*;

    logic stb_rise, stb_fall, stb_any;
    logic win_start, win_abort, win_done;

    ctl_state_t state_q, state_d;
    logic       pulse_q, pulse_d;
    logic       reinit_q, reinit_d;
    logic       on_q, on_d;
    copy_cfg_t  cfg;

    disp_strobe_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .strobe   (strobe),
        .rise     (stb_rise),
        .fall     (stb_fall),
        .any_edge (stb_any)
    );

    disp_copy_window #(.WIN_TICKS(WIN_TICKS)) u_win (
        .clk   (clk),
        .rst   (rst),
        .start (win_start),
        .abort (win_abort),
        .tick  (osc_tick),
        .done  (win_done)
    );

    assign cfg = '{mode: latch_mode, every: latch_every, data: data_seen};

    always_comb begin
        state_d   = state_q;
        pulse_d   = 1'b0;
        reinit_d  = 1'b0;
        on_d      = on_q;
        win_start = 1'b0;
        win_abort = 1'b0;
        unique case (state_q)
            ST_POWERUP: begin
                if (stb_any) begin
                    state_d  = ST_READY;
                    reinit_d = 1'b1;
                end
            end
            ST_READY: begin
                if (stb_rise) begin
                    if (stat_pend) on_d = stat_on;
                    if (copy_wanted(cfg)) begin
                        state_d   = ST_COPY;
                        pulse_d   = 1'b1;
                        win_start = 1'b1;
                    end
                end
            end
            ST_COPY: begin
                if (stb_any) begin
                    state_d   = ST_READY;
                    win_abort = 1'b1;
                    reinit_d  = 1'b1;
                    on_d      = 1'b0;
                end else if (win_done) begin
                    state_d = ST_READY;
                end
            end
            default: state_d = ST_POWERUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_POWERUP;
            pulse_q  <= 1'b0;
            reinit_q <= 1'b0;
            on_q     <= 1'b0;
        end else begin
            state_q  <= state_d;
            pulse_q  <= pulse_d;
            reinit_q <= reinit_d;
            on_q     <= on_d;
        end
    end

    assign busy        = (state_q == ST_READY);
    assign latch_pulse = pulse_q;
    assign ser_reinit  = reinit_q;
    assign disp_on     = on_q;
    assign disp_active = on_q & disp_off_n;

    // R2
    powerup_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_POWERUP && stb_any) |=> (busy && ser_reinit && !latch_pulse));

    // R3
    copy_needs_rise_chk: assert property (@(posedge clk) disable iff (rst)
        latch_pulse |-> $past(stb_rise));

    // R4
    copy_holds_busy_chk: assert property (@(posedge clk) disable iff (rst)
        latch_pulse |-> !busy);

    // R6
    abort_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COPY && stb_any) |=> (busy && ser_reinit && !disp_on && !latch_pulse));

    // R7
    enable_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(disp_on) |-> $past(stb_rise && stat_pend && stat_on));
endmodule

// File: tb/sim_disp_latch_ctrl.sv
module sim_disp_latch_ctrl;
    localparam int WIN = 13;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic osc_tick = 1'b0;
    logic strobe = 1'b1;
    logic latch_mode = 1'b0, latch_every = 1'b0, data_seen = 1'b0;
    logic stat_pend = 1'b0, stat_on = 1'b0, disp_off_n = 1'b1;
    logic busy, latch_pulse, ser_reinit, disp_on, disp_active;

    int checks = 0;
    int errors = 0;
    int tick_div = 1;
    int cyc = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    disp_latch_ctrl #(.WIN_TICKS(WIN)) u0 (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .strobe(strobe),
        .latch_mode(latch_mode), .latch_every(latch_every), .data_seen(data_seen),
        .stat_pend(stat_pend), .stat_on(stat_on), .disp_off_n(disp_off_n),
        .busy(busy), .latch_pulse(latch_pulse), .ser_reinit(ser_reinit),
        .disp_on(disp_on), .disp_active(disp_active)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        osc_tick <= ((cyc % tick_div) == 0);
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_strobe(input logic v);
        strobe = v;
        step();
    endtask

    task automatic measure(input int exp_ticks, input string req);
        int t = 0;
        int c = 0;
        while (busy == 1'b0 && c < 1000) begin
            if (osc_tick) t++;
            if (c == 1) chk(latch_pulse == 1'b0, {req, " pulse width"}, latch_pulse, 0);
            c++;
            step();
        end
        chk(t == exp_ticks, req, t, exp_ticks);
        chk(busy == 1'b1, {req, " ready after window"}, busy, 1);
    endtask

    initial begin
        int wd = 0;
        while (!done_flag) begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(disp_on == 1'b0, "R1 disp_on", disp_on, 0);
        chk(latch_pulse == 1'b0, "R1 latch_pulse", latch_pulse, 0);
        latch_every = 1'b1; stat_pend = 1'b1; stat_on = 1'b1;
        repeat (5) step();
        chk(busy == 1'b0 && latch_pulse == 1'b0 && disp_on == 1'b0, "R1 hold without strobe edge",
            {busy, latch_pulse, disp_on}, 0);

        // R2 first edge (falling) leaves power-up
        set_strobe(1'b0);
        chk(busy == 1'b1, "R2 busy after first edge", busy, 1);
        chk(ser_reinit == 1'b1, "R2 reinit pulse", ser_reinit, 1);
        chk(latch_pulse == 1'b0, "R2 no copy", latch_pulse, 0);
        step();
        chk(ser_reinit == 1'b0, "R2 reinit one cycle", ser_reinit, 0);
        latch_every = 1'b0; stat_pend = 1'b0; stat_on = 1'b0;
        set_strobe(1'b1);

        // R3 / R4 sweep over all flag combinations
        for (int k = 0; k < 8; k++) begin
            bit m, e, d, want;
            m = k[2]; e = k[1]; d = k[0];
            want = e | (m & d);
            latch_mode = m; latch_every = e; data_seen = d;
            set_strobe(1'b0);
            chk(latch_pulse == 1'b0 && busy == 1'b1, "R3 falling edge no copy",
                {latch_pulse, busy}, 1);
            repeat (2) step();
            set_strobe(1'b1);
            chk(latch_pulse == want, $sformatf("R3 decode k=%0d", k), latch_pulse, want);
            chk(busy == !want, $sformatf("R4 busy low with copy k=%0d", k), busy, !want);
            if (want) measure(WIN, "R4 window ticks");
            step();
        end

        // R5 gapped ticks
        tick_div = 3;
        latch_mode = 1'b0; latch_every = 1'b1; data_seen = 1'b0;
        set_strobe(1'b0);
        set_strobe(1'b1);
        chk(latch_pulse == 1'b1, "R5 copy started", latch_pulse, 1);
        measure(WIN, "R5 gapped window ticks");
        tick_div = 1;

        // R7 display enable
        latch_every = 1'b0;
        stat_pend = 1'b1; stat_on = 1'b1;
        set_strobe(1'b0);
        set_strobe(1'b1);
        chk(disp_on == 1'b1, "R7 load on", disp_on, 1);
        chk(disp_active == 1'b1, "R8 active with pin high", disp_active, 1);
        stat_pend = 1'b0; stat_on = 1'b0;
        set_strobe(1'b0);
        set_strobe(1'b1);
        chk(disp_on == 1'b1, "R7 hold without pending status", disp_on, 1);

        // R8 blanking pin
        disp_off_n = 1'b0;
        step();
        chk(disp_active == 1'b0, "R8 blanked", disp_active, 0);
        chk(disp_on == 1'b1, "R8 flag kept", disp_on, 1);
        latch_every = 1'b1;
        set_strobe(1'b0);
        set_strobe(1'b1);
        chk(latch_pulse == 1'b1, "R8 copy while blanked", latch_pulse, 1);

        // R6 abort during window
        repeat (3) step();
        chk(busy == 1'b0, "R6 window open", busy, 0);
        set_strobe(1'b0);
        chk(busy == 1'b1, "R6 busy after abort", busy, 1);
        chk(ser_reinit == 1'b1, "R6 reinit", ser_reinit, 1);
        chk(disp_on == 1'b0, "R6 display off", disp_on, 0);
        chk(latch_pulse == 1'b0, "R6 no copy", latch_pulse, 0);
        repeat (WIN + 2) step();
        chk(busy == 1'b1, "R6 stays ready", busy, 1);
        disp_off_n = 1'b1;
        set_strobe(1'b1);
        chk(latch_pulse == 1'b1, "R6 next frame copies", latch_pulse, 1);
        measure(WIN, "R6 full window after abort");

        // R7 clear via status
        stat_pend = 1'b1; stat_on = 1'b1; latch_every = 1'b0;
        set_strobe(1'b0);
        set_strobe(1'b1);
        stat_on = 1'b0;
        set_strobe(1'b0);
        set_strobe(1'b1);
        chk(disp_on == 1'b0, "R7 load off", disp_on, 0);

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule